// File: doc/BRIEF.md
# Paged EEPROM Write-Cycle Controller

This block is a synchronous model of the write path of a byte-wide non-volatile memory. Software sees an SRAM-like port with three active-low strobes: chip enable, output enable and write enable. All of them are sampled on the system clock. A write gathers bytes into a page buffer. Every following byte of the same page must arrive before a page-load timer runs out. When the timer expires, an internally timed programming cycle copies the loaded bytes into a behavioural storage array.

From the first byte of a page load until programming completes, a read returns a status byte instead of memory data. The top bit carries the inverted bit 7 of the last byte written. The next bit flips on each successive read. The third bit shows whether the load timer has expired. The page load has no commit command; it always ends by timeout.

The controller has three states. `ST_IDLE` is the resting state, where reads return the array. `ST_LOAD` is the page-load window. `ST_PROG` is the internal programming cycle. The transitions are:
- IDLE→LOAD on the first completed write strobe.
- LOAD→LOAD on each further byte, which restarts the timer.
- LOAD→PROG on timeout when every byte shared one page.
- LOAD→IDLE on timeout when the page check failed; the load is discarded.
- PROG→IDLE when the programming counter expires; the buffer is committed at that moment.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: A read is active when `ce_n` and `oe_n` are both low and `we_n` is high. While a read is active, `dout_en` is 1. In `ST_IDLE`, `dout` is the stored byte at `addr` in the same cycle. With no read active, `dout_en` is 0 and `dout` is 0.
- R2: A write strobe is active while `ce_n` and `we_n` are both low and `oe_n` is high, so either `ce_n` or `we_n` can control the cycle. `addr` is captured in the first clock where the strobe is seen active, which is after the later of the two falls. `din` is captured in the first clock where the strobe is seen inactive, which is after the earlier of the two rises. Changes outside those two samples have no effect.
- R3: A completed write in `ST_IDLE` starts a page load. While busy (load or programming), a read returns a status byte. Bit 7 is the inverse of bit 7 of the last byte written. Bit 6 is the toggle bit. Bit 5 is the timer-status bit, which is 0 during the load. Bits 4..0 are 0.
- R4: The page-load window closes LOAD_TIMEOUT clocks after the capture clock of the last byte, unless another byte is captured first, which restarts the window. Programming then starts and status bit 5 reads 1.
- R5: Programming lasts PROG_CYCLES clocks. After that, reads return memory contents again, and the programmed bytes read back.
- R6: Every byte of one page load must share the address bits above the low 6 (the page number). If any byte names a different page, nothing from that load is programmed and the memory is unchanged.
- R7: Programming writes only the byte offsets loaded in that page load. Other offsets of the page keep their previous contents.
- R8: Write strobes completed during programming are ignored and do not alter the memory.
- R9: The toggle bit reads 0 on the first status read of each load-and-program episode. It flips after each completed read while busy.
- R10: After reset the controller is in `ST_IDLE` with no read output enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address; upper bits form the page number |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data or status byte |
| dout_en | output | 1 | High while a read drives the data bus |

## Verification
The checker watches the following on every cycle:
- the data bus stays quiet when no read is active;
- programming is entered only from the load state;
- the load state always holds at least one buffered byte;
- the buffer is frozen through programming;
- the buffer is empty once the controller has rested idle;
- status bit 5 is set on any read during programming.

Only the directed scenarios can show the rest. These are:
- the exact clocks where the load window closes and programming ends;
- the toggle sequence;
- the inverted polled bit;
- which strobe edge captures the address and which captures the data;
- that an aborted page or a write during programming leaves the array contents untouched.

// File: rtl/eepc_pkg.sv
package eepc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } eepc_state_t;
endpackage

// File: rtl/eepc_strobe.sv
module eepc_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_start,
    output logic wr_end,
    output logic rd_active,
    output logic rd_end
);
    logic wr_act;
    logic wr_q;
    logic rd_q;

    assign wr_act    = !ce_n && !we_n && oe_n;
    assign rd_active = !ce_n && !oe_n && we_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_active;
        end
    end

    // Strobe becomes active after the later falling enable, and inactive after the earlier rising one.
    assign wr_start = wr_act && !wr_q;
    assign wr_end   = !wr_act && wr_q;
    assign rd_end   = !rd_active && rd_q;
endmodule

// File: rtl/eepc_page_buf.sv
module eepc_page_buf #(
    parameter int DATA_W     = 8,
    parameter int OFS_W      = 6,
    localparam int PAGE_BYTES = 1 << OFS_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clear,
    input  logic                              wr_en,
    input  logic [OFS_W-1:0]                  wr_ofs,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [PAGE_BYTES-1:0]             mask,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else begin
            if (clear) mask <= '0;
            if (wr_en) mask[wr_ofs] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) data[wr_ofs] <= wr_data;
    end
endmodule

// File: rtl/eepc_timer.sv
module eepc_timer #(
    parameter int LIMIT = 100,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic expired
);
    logic [CNT_W-1:0] cnt;

    assign expired = run && !restart && (cnt == CNT_W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (restart)    cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (!expired)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
    import eepc_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int DATA_W       = 8,
    parameter int OFS_W        = 6,
    parameter int LOAD_TIMEOUT = 100,
    parameter int PROG_CYCLES  = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    localparam int PAGE_BYTES = 1 << OFS_W;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_W     = ADDR_W - OFS_W;

    eepc_state_t state_q, state_d;

    logic                              wr_start, wr_end, rd_active, rd_end;
    logic [ADDR_W-1:0]                 addr_q;
    logic [PAGE_W-1:0]                 page_q;
    logic                              abort_q;
    logic [DATA_W-1:0]                 last_q;
    logic                              tgl_q;
    logic                              load_exp, prog_exp;
    logic                              take_byte, page_ok;
    logic [PAGE_BYTES-1:0]             buf_mask;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_data;
    logic [DATA_W-1:0]                 mem [DEPTH];

    eepc_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wr_start(wr_start), .wr_end(wr_end), .rd_active(rd_active), .rd_end(rd_end)
    );

    eepc_timer #(.LIMIT(LOAD_TIMEOUT)) u_load_tmr (
        .clk(clk), .rst_n(rst_n), .restart(wr_end),
        .run(state_q == ST_LOAD), .expired(load_exp)
    );

    eepc_timer #(.LIMIT(PROG_CYCLES)) u_prog_tmr (
        .clk(clk), .rst_n(rst_n), .restart(1'b0),
        .run(state_q == ST_PROG), .expired(prog_exp)
    );

    assign page_ok   = (state_q == ST_IDLE) || (addr_q[ADDR_W-1:OFS_W] == page_q);
    assign take_byte = wr_end && (state_q != ST_PROG);

    eepc_page_buf #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .clear(state_q == ST_IDLE),
        .wr_en(take_byte && page_ok),
        .wr_ofs(addr_q[OFS_W-1:0]),
        .wr_data(din),
        .mask(buf_mask),
        .data(buf_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wr_end)   state_d = ST_LOAD;
            ST_LOAD: if (load_exp) state_d = abort_q ? ST_IDLE : ST_PROG;
            ST_PROG: if (prog_exp) state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // Capture registers, page check and toggle bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            page_q  <= '0;
            abort_q <= 1'b0;
            last_q  <= '0;
            tgl_q   <= 1'b0;
        end else begin
            if (wr_start) addr_q <= addr;
            if (take_byte) begin
                last_q <= din;
                if (state_q == ST_IDLE) begin
                    page_q  <= addr_q[ADDR_W-1:OFS_W];
                    abort_q <= 1'b0;
                end else if (!page_ok) begin
                    abort_q <= 1'b1;
                end
            end
            if (state_q == ST_IDLE)  tgl_q <= 1'b0;
            else if (rd_end)         tgl_q <= !tgl_q;
        end
    end

    // Commit of the loaded bytes at the end of programming
    always_ff @(posedge clk) begin
        if (state_q == ST_PROG && prog_exp) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (buf_mask[i]) mem[{page_q, OFS_W'(i)}] <= buf_data[i];
            end
        end
    end

    // Outputs
    always_comb begin
        dout_en = rd_active;
        dout    = '0;
        if (rd_active) begin
            if (state_q == ST_IDLE) begin
                dout = mem[addr];
            end else begin
                dout[DATA_W-1] = !last_q[DATA_W-1];
                dout[DATA_W-2] = tgl_q;
                dout[DATA_W-3] = (state_q == ST_PROG);
            end
        end
    end
endmodule

// File: rtl/eepc_checks.sv
module eepc_checks
    import eepc_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input eepc_state_t           state_q,
    input logic [PAGE_BYTES-1:0] buf_mask,
    input logic [DATA_W-1:0]     dout,
    input logic                  dout_en
);
    a_r1_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> dout == '0);

    a_r3_load_holds_byte: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOAD |-> buf_mask != '0);

    a_r4_prog_from_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && $past(state_q) != ST_PROG) |-> $past(state_q) == ST_LOAD);

    a_r5_busy_status: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && state_q == ST_PROG) |-> dout[DATA_W-3]);

    a_r7_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> buf_mask == '0);

    a_r8_frozen_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && $past(state_q) == ST_PROG) |-> $stable(buf_mask));
endmodule

bind eeprom_page_ctrl eepc_checks #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .buf_mask(buf_mask),
    .dout(dout), .dout_en(dout_en)
);

// File: tb/tb_eeprom_page_ctrl.sv
module tb_eeprom_page_ctrl;
    localparam int LT = 20;
    localparam int PG = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [9:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_en;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] model [1024];

    always #2 clk = !clk;

    eeprom_page_ctrl #(.ADDR_W(10), .DATA_W(8), .OFS_W(6),
                       .LOAD_TIMEOUT(LT), .PROG_CYCLES(PG)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; din = d; ce_n = 0; we_n = 0;
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1;
    endtask

    task automatic rd_byte(input logic [9:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
        #1 d = dout;
        @(negedge clk); ce_n = 1; oe_n = 1;
    endtask

    task automatic wait_done();
        repeat (LT + PG + 4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 dout_en after reset", {7'b0, dout_en}, 8'h00);
        chk("R10 dout after reset", dout, 8'h00);
        @(negedge clk); ce_n = 0; #1;
        chk("R1 oe_n high no drive", {7'b0, dout_en}, 8'h00);
        @(negedge clk); ce_n = 1;
    endtask

    task automatic t_full_page();
        logic [7:0] v;
        for (int i = 0; i < 64; i++) begin
            wr_byte(10'(i), 8'(i * 7 + 11));
            model[i] = 8'(i * 7 + 11);
        end
        repeat (LT - 1) @(negedge clk);
        addr = 10'd63; ce_n = 0; oe_n = 0; #1;
        chk("R3 load status (dq5 low, toggle 0)", dout, 8'h00);
        chk("R1 dout_en during read", {7'b0, dout_en}, 8'h01);
        @(negedge clk); ce_n = 1; oe_n = 1;
        @(negedge clk); ce_n = 0; oe_n = 0; #1;
        chk("R4 timeout status dq5 high, R9 toggled", dout, 8'h60);
        repeat (PG - 2) @(negedge clk); #1;
        chk("R5 still programming", dout, 8'h60);
        @(negedge clk); #1;
        chk("R5 data after programming", dout, 8'hC4);
        @(negedge clk); ce_n = 1; oe_n = 1;
        for (int i = 0; i < 64; i += 9) begin
            rd_byte(10'(i), v);
            chk("R1 readback", v, model[i]);
        end
    endtask

    task automatic t_ce_ctrl();
        logic [7:0] v;
        @(negedge clk); addr = 10'd70; din = 8'h4B; we_n = 0;
        @(negedge clk); ce_n = 0;
        @(negedge clk); addr = 10'd99; ce_n = 1;
        @(negedge clk); din = 8'hFF; we_n = 1;
        model[70] = 8'h4B;
        wait_done();
        rd_byte(10'd70, v);
        chk("R2 CE-controlled capture", v, 8'h4B);
    endtask

    task automatic t_partial();
        logic [7:0] v;
        wr_byte(10'd3, 8'hA5); model[3] = 8'hA5;
        wr_byte(10'd5, 8'h3C); model[5] = 8'h3C;
        wait_done();
        rd_byte(10'd3, v); chk("R7 loaded offset 3", v, model[3]);
        rd_byte(10'd4, v); chk("R7 unloaded offset 4 kept", v, model[4]);
        rd_byte(10'd5, v); chk("R7 loaded offset 5", v, model[5]);
    endtask

    task automatic t_mismatch();
        logic [7:0] v;
        wr_byte(10'd8, 8'h11);
        wr_byte(10'd70, 8'h22);
        wait_done();
        rd_byte(10'd8, v);  chk("R6 page mismatch addr 8", v, model[8]);
        rd_byte(10'd70, v); chk("R6 page mismatch addr 70", v, model[70]);
    endtask

    task automatic t_prog_ignore();
        logic [7:0] v;
        wr_byte(10'd10, 8'h77); model[10] = 8'h77;
        repeat (LT) @(negedge clk);
        wr_byte(10'd70, 8'h5A);
        rd_byte(10'd10, v);
        chk("R8 programming status, R9 first toggle 0", v, 8'hA0);
        wait_done();
        rd_byte(10'd10, v); chk("R8 programmed byte", v, 8'h77);
        rd_byte(10'd70, v); chk("R8 write during programming ignored", v, model[70]);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_full_page();
        t_ce_ctrl();
        t_partial();
        t_mismatch();
        t_prog_ignore();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule